// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host port and a 32-bit bank of asynchronous static RAM made from four byte-wide devices that share address, chip select and output enable. Each byte device has its own write strobe. The host presents one request at a time: a read or a write, a 19-bit word address, 32 bits of write data and a 4-bit byte mask. The controller answers with a one-clock `done` pulse. For a read, the fetched word appears on `rdata` in that same cycle.

On the memory side the controller sequences the chip select, the output enable, the four lane write enables and the data-bus drive enable. The bus is modelled as split out/in/enable signals. The setup, strobe and cycle times are given in nanoseconds as parameters. Each is turned into a whole number of clocks using the clock-period parameter, rounded up and never below one.

A second chip select, for a flash device that shares the data bus, is an output held inactive at all times. The flash therefore never drives the bus while the SRAM is selected.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `mem_cs_n` is high, all four `mem_we_n` bits and `mem_oe_n` are high and `mem_dq_oe` is low. This is also the state during reset and between accesses.
- R2: `flash_cs_n` is high in every cycle, including every cycle in which `mem_cs_n` is low.
- R3: A read drives `mem_oe_n` low only while `mem_cs_n` is low and all write enables are high. The word sampled from `mem_dq_in` is presented on `rdata` in the cycle `done` is high.
- R4: Whenever any write enable is low, `mem_oe_n` is high and `mem_dq_oe` is high, so the write data is on the bus for the whole strobe.
- R5: Bit i of the byte mask selects lane i (data bits 8i+7..8i). Only lanes whose mask bit is 1 get a write-enable pulse, so unselected bytes keep their contents. A mask of 0 strobes no lane.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. In the cycle before `mem_oe_n` falls, `mem_dq_oe` is already low.
- R7: A write enable goes low only after at least ceil(3 ns / period) cycles of chip select low with a stable address. It stays low for ceil(20 ns / period) cycles. The write keeps chip select low for at least ceil(25 ns / period) cycles. Each count is at least 1; at 20 ns this gives 1 setup, 1 strobe and 3 cycles in total.
- R8: A read keeps chip select low for one turnaround cycle, then holds output enable low for max(ceil(25 ns / period), ceil(15 ns / period)) cycles. At 20 ns this is 2 cycles, and the read has 3 chip-select-low cycles. Data is captured in the last cycle with output enable low.
- R9: `req_ready` is high only when no access is in progress. Each accepted request produces exactly one `done` pulse, one clock wide, in request order.
- R10: `mem_addr` does not change while `mem_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte-lane mask for writes |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with done |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Shared SRAM chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_we_n | output | 4 | Per-lane write enables, active low |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Host drive enable for the data bus |
| mem_dq_in | input | 32 | Data returned by memory |
| flash_cs_n | output | 1 | Flash chip select, held inactive |

## Verification
The completion pulse of one access can fall in the same cycle as the acceptance of the next request. The bench provokes this by keeping `req_valid` asserted across mixed back-to-back reads and writes. It judges the result with a scoreboard that must see exactly one `done` per request, in order and with the right data. It also requires chip select to rise for that one idle cycle, and the per-access counts of chip-select, strobe and output-enable cycles must match R7 and R8 exactly. Partial and empty masks are read back to show that untouched lanes keep their data.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int CLK_NS  = 20,
  parameter int ADDR_W  = 19,
  parameter int LANES   = 4,
  parameter int T_AS_NS = 3,
  parameter int T_WP_NS = 20,
  parameter int T_WC_NS = 25,
  parameter int T_RC_NS = 25,
  parameter int T_OE_NS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [8*LANES-1:0]   req_wdata,
  input  logic [LANES-1:0]     req_mask,
  output logic                 req_ready,
  output logic                 done,
  output logic [8*LANES-1:0]   rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_cs_n,
  output logic                 mem_oe_n,
  output logic [LANES-1:0]     mem_we_n,
  output logic [8*LANES-1:0]   mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [8*LANES-1:0]   mem_dq_in,
  output logic                 flash_cs_n
);
  localparam int DATA_W = 8 * LANES;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_C = to_cyc(T_AS_NS);
  localparam int PULSE_C = to_cyc(T_WP_NS);
  localparam int WC_C    = to_cyc(T_WC_NS);
  localparam int REC_C   = (WC_C > SETUP_C + PULSE_C) ? WC_C - SETUP_C - PULSE_C : 1;
  localparam int RD_C    = (to_cyc(T_RC_NS) > to_cyc(T_OE_NS)) ? to_cyc(T_RC_NS) : to_cyc(T_OE_NS);
  localparam int MAX_A   = (SETUP_C > PULSE_C) ? SETUP_C : PULSE_C;
  localparam int MAX_B   = (REC_C > RD_C) ? REC_C : RD_C;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WREC, S_RGAP, S_RACC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  assign req_ready  = (st == S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_cs_n   = (st == S_IDLE);
  assign mem_oe_n   = (st != S_RACC);
  assign mem_we_n   = (st == S_WPUL) ? ~mask_q : {LANES{1'b1}};
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (st == S_WSET) || (st == S_WPUL) || (st == S_WREC);
  assign flash_cs_n = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_write ? req_mask : '0;
          if (req_write) begin
            st  <= S_WSET;
            cnt <= CNT_W'(SETUP_C - 1);
          end else begin
            st  <= S_RGAP;
            cnt <= '0;
          end
        end
        S_WSET: if (cnt == '0) begin
          st  <= S_WPUL;
          cnt <= CNT_W'(PULSE_C - 1);
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (cnt == '0) begin
          st  <= S_WREC;
          cnt <= CNT_W'(REC_C - 1);
        end else cnt <= cnt - 1'b1;
        S_WREC: if (cnt == '0) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_RGAP: begin
          st  <= S_RACC;
          cnt <= CNT_W'(RD_C - 1);
        end
        S_RACC: if (cnt == '0) begin
          rdata <= mem_dq_in;
          st    <= S_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              req_ready
);
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (&mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_read_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && &mem_we_n));

  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_we_n) |-> (mem_oe_n && mem_dq_oe));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_addr_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_we_n) && &$past(mem_we_n)) |-> (!$past(mem_cs_n) && $stable(mem_addr)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
  .done(done), .req_ready(req_ready)
);

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
  // 20 ns period: write = 1 setup + 1 strobe + 1 recovery, read = 1 gap + 2 OE-low
  localparam int WR_CS = 3, WR_WE = 1, RD_CS = 3, RD_OE = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic req_ready, done;
  logic [31:0] rdata;
  logic [18:0] mem_addr;
  logic mem_cs_n, mem_oe_n, mem_dq_oe, flash_cs_n;
  logic [3:0]  mem_we_n;
  logic [31:0] mem_dq_out, mem_dq_in;

  always #10 clk = ~clk;

  sram_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .flash_cs_n(flash_cs_n)
  );

  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct { bit rd; logic [31:0] exp; logic [3:0] mask; } item_t;
  item_t q[$];

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 32'hDEAD_BEEF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [31:0] d, input logic [3:0] m);
    item_t it;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    it.rd = !wr;
    it.mask = wr ? m : 4'h0;
    it.exp = '0;
    if (wr) begin
      for (int l = 0; l < 4; l++)
        if (m[l]) shadow[a[7:0]][8*l +: 8] = d[8*l +: 8];
    end else it.exp = shadow[a[7:0]];
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  // memory model and protocol monitor
  int cs_cnt = 0, we_cnt = 0, oe_cnt = 0;
  bit v1, v2, v4, v5, v6, v7, v10;
  logic p_cs_n = 1, p_oe_n = 1, p_dq_oe = 0, p_done = 0;
  logic [3:0] p_we = 4'hF;
  logic [18:0] p_addr = '0;

  always @(negedge clk) if (rst_n && !finished) begin
    item_t it;
    if (!mem_cs_n) cs_cnt++;
    if (mem_we_n != 4'hF) we_cnt++;
    if (!mem_oe_n) oe_cnt++;
    if (mem_cs_n && (mem_we_n != 4'hF || !mem_oe_n || mem_dq_oe)) v1 = 1;
    if (!flash_cs_n) v2 = 1;
    if (mem_we_n != 4'hF && (!mem_oe_n || !mem_dq_oe)) v4 = 1;
    if (q.size() > 0 && ((~mem_we_n) & ~q[0].mask) != 4'h0) v5 = 1;
    if (!mem_oe_n && mem_dq_oe) v6 = 1;
    if (!mem_oe_n && p_oe_n && p_dq_oe) v6 = 1;
    if (mem_we_n != 4'hF && p_we == 4'hF && (p_cs_n || p_addr != mem_addr)) v7 = 1;
    if (!mem_cs_n && !p_cs_n && mem_addr != p_addr) v10 = 1;
    if (!mem_cs_n)
      for (int l = 0; l < 4; l++)
        if (!mem_we_n[l]) mem[mem_addr[7:0]][8*l +: 8] = mem_dq_out[8*l +: 8];
    if (done) begin
      chk(!p_done, "R9 done one clock", {31'd0, p_done}, 32'd0);
      chk(req_ready, "R9 ready with done", {31'd0, req_ready}, 32'd1);
      if (q.size() == 0) chk(0, "R9 unexpected done", 32'd1, 32'd0);
      else begin
        it = q.pop_front();
        if (it.rd) begin
          chk(rdata === it.exp, "R3 read data", rdata, it.exp);
          chk(cs_cnt == RD_CS, "R8 read cs cycles", cs_cnt, RD_CS);
          chk(oe_cnt == RD_OE, "R8 oe-low cycles", oe_cnt, RD_OE);
        end else begin
          chk(cs_cnt == WR_CS, "R7 write cs cycles", cs_cnt, WR_CS);
          chk(we_cnt == ((it.mask != 0) ? WR_WE : 0), "R7 strobe cycles", we_cnt,
              (it.mask != 0) ? WR_WE : 0);
          chk(oe_cnt == 0, "R4 oe during write", oe_cnt, 0);
        end
      end
      chk(!v1, "R1 standby", v1, 0);
      chk(!v2, "R2 flash select", v2, 0);
      chk(!v4, "R4 write overrides oe", v4, 0);
      chk(!v5, "R5 lane strobes", v5, 0);
      chk(!v6, "R6 bus turnaround", v6, 0);
      chk(!v7, "R7 address setup", v7, 0);
      chk(!v10, "R10 address stable", v10, 0);
      cs_cnt = 0; we_cnt = 0; oe_cnt = 0;
      v1 = 0; v2 = 0; v4 = 0; v5 = 0; v6 = 0; v7 = 0; v10 = 0;
    end
    p_cs_n = mem_cs_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_we = mem_we_n;
    p_addr = mem_addr; p_done = done;
  end

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i * 32'h0101_0101) ^ 32'h5A5A_0000;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n == 4'hF && !mem_dq_oe, "R1 reset outputs",
        {mem_cs_n, mem_oe_n, mem_dq_oe, mem_we_n}, {3'b110, 4'hF});
    chk(flash_cs_n, "R2 reset flash", flash_cs_n, 1);
    chk(!done, "R9 reset done", done, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R9 idle ready", req_ready, 1);

    issue(1, 19'd5, 32'h1122_3344, 4'hF); repeat (2) @(negedge clk);
    issue(0, 19'd5, '0, '0);              repeat (2) @(negedge clk);
    // partial write R5: lanes 0 and 2
    issue(1, 19'd5, 32'hAABB_CCDD, 4'b0101); @(negedge clk);
    issue(0, 19'd5, '0, '0);                 @(negedge clk);
    // empty mask R5: no change
    issue(1, 19'd5, 32'hFFFF_FFFF, 4'b0000);
    issue(0, 19'd5, '0, '0);
    chk(!req_valid && q.size() <= 1, "R9 queue drain", q.size(), 1);
    // back-to-back mix: done and next acceptance in the same cycle
    issue(1, 19'd9, 32'hCAFE_F00D, 4'hF);
    issue(0, 19'd9, '0, '0);
    issue(1, 19'd10, 32'h8800_0000, 4'b1000);
    issue(0, 19'd10, '0, '0);
    issue(0, 19'd5, '0, '0);
    issue(0, 19'h7FFFF, '0, '0);
    issue(1, 19'h7FFFF, 32'h0123_4567, 4'b0110);
    issue(0, 19'h7FFFF, '0, '0);
    for (int i = 0; i < 8; i++) begin
      issue(1, 19'(32 + i), 32'h1357_9BDF ^ (i * 32'h0F0F_1111), 4'(i + 1));
      issue(0, 19'(32 + i), '0, '0);
      if (i % 2 == 1) repeat (i) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 all requests done", q.size(), 0);
    chk(mem_cs_n && flash_cs_n && !mem_dq_oe, "R1 idle after run",
        {mem_cs_n, flash_cs_n, mem_dq_oe}, 3'b110);
    finish_run();
  end
endmodule